// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift/rotate slice of a processor integer datapath. Each operation takes an operation code, a destination operand, a second operand (used only by the double-precision shifts), a shift count, an operand size of 8, 16 or 32 bits and the incoming carry flag. It returns the shifted or rotated result together with carry, overflow, zero, sign and parity flags. Each flag has its own update bit, so the surrounding core knows which architectural flags to write back and which to leave alone.

The unit accepts one request per cycle on a `start` strobe. The outputs are registered, so `done` and the result appear one clock after `start`. The outputs then hold until the next request. Decode, operand fetch and the other ALU functions live elsewhere.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation codes are 0 SHL, 1 SHR, 2 SAR, 3 ROL, 4 ROR, 5 RCL, 6 RCR, 7 SHLD, 8 SHRD. Sizes are 0 = 8, 1 = 16 and 2 = 32 bits. For SHL, SHR and SAR, the vacated positions take zeros (SHL, SHR) or copies of the original sign bit (SAR). The carry is the last bit moved out, and result bits at and above the operand width read zero.
- R2: SAR rounds toward negative infinity: 16-bit 0xFFF1 (-15) shifted right by 1 gives 0xFFF8 (-8) with carry 1.
- R3: Overflow is flagged as updated only when the effective count is 1. Its value is then: for SHL, ROL and RCL, result MSB xor new carry; for SHR, the original MSB; for SAR, 0; for ROR and RCR, the xor of the two top result bits; for SHLD and SHRD, result MSB xor original MSB.
- R4: A request is illegal when any of these holds: the size is 3; the operation code is above 8; a SHLD or SHRD has size 8; or a SHLD or SHRD has an effective count not below the width. An illegal request sets `illegal`, returns result 0 and updates no flag.
- R5: SHLD shifts the destination left and fills the low bits from the top of the second operand. SHRD shifts right and fills the high bits from the bottom of the second operand. In both, the carry is the last destination bit moved out.
- R6: RCL and RCR rotate the (width+1)-bit value formed by the carry above the destination. The rotation amount is the effective count modulo width+1. The new carry is the top bit of that rotated value.
- R7: ROL and ROR rotate by the effective count modulo the width. After ROL the carry equals result bit 0; after ROR it equals the result MSB.
- R8: Rotates update carry (and overflow per R3) only. The zero, sign and parity update bits stay clear.
- R9: Only bits 4:0 of the count are used. An effective count of 0 returns the destination (masked to size) with no flag updated.
- R10: Shifts (SHL, SHR, SAR, SHLD, SHRD) update zero (result == 0), sign (result MSB) and parity (1 when result bits 7:0 hold an even number of ones). Update bits are {PF, SF, ZF, OF, CF} in bits 4..0, and a flag output whose update bit is clear reads 0.
- R11: `done` is high exactly in the cycle after `start`. Result, flags and `illegal` then hold until the next `start`.
- R12: After reset, `done`, `result`, all flags, the update mask and `illegal` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, one operation per high cycle |
| op | input | 4 | Operation code (R1) |
| size | input | 2 | Operand size code (R1) |
| dst | input | 32 | Destination operand |
| src | input | 32 | Fill operand for SHLD/SHRD |
| count | input | 8 | Shift count, low 5 bits used |
| carry_in | input | 1 | Incoming carry flag |
| done | output | 1 | Result valid strobe |
| result | output | 32 | Shifted/rotated result |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| pf | output | 1 | Parity flag |
| flag_upd | output | 5 | Per-flag update mask {PF,SF,ZF,OF,CF} |
| illegal | output | 1 | Illegal request indicator |

## Verification
The bench sweeps every operation, size and count, with high count bits set and both carry values, over several data patterns. It compares every output against a bit-at-a-time model. The sweep targets several corner cases:
- Counts at and beyond the width. A shifter that wraps the count would return stale bits or a wrong carry there.
- RCL and RCR counts equal to width+1. A design that rotates modulo the width instead of width+1 would lose the carry bit.
- Counts other than 1. A design that did not gate the overflow update would raise overflow there.
- Rotates. A design that touched the zero, sign or parity flags on a rotate would clobber them.

Directed checks cover negative SAR rounding and illegal double shifts, including the 8-bit case and counts at the width.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int SRU_XLEN  = 32;
    localparam int SRU_CNT_W = 5;
    localparam int SRU_EXT_W = 3 * SRU_XLEN;
    localparam int SRU_NFLAG = 5;

    localparam int FL_CF = 0;
    localparam int FL_OF = 1;
    localparam int FL_ZF = 2;
    localparam int FL_SF = 3;
    localparam int FL_PF = 4;

    typedef enum logic [3:0] {
        OP_SHL  = 4'd0,
        OP_SHR  = 4'd1,
        OP_SAR  = 4'd2,
        OP_ROL  = 4'd3,
        OP_ROR  = 4'd4,
        OP_RCL  = 4'd5,
        OP_RCR  = 4'd6,
        OP_SHLD = 4'd7,
        OP_SHRD = 4'd8
    } sru_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } sru_size_e;

    function automatic logic [SRU_XLEN-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = SRU_XLEN'(32'h0000_00FF);
            2'd1:    size_mask = SRU_XLEN'(32'h0000_FFFF);
            default: size_mask = {SRU_XLEN{1'b1}};
        endcase
    endfunction

    function automatic logic [6:0] size_bits(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bits = 7'd8;
            2'd1:    size_bits = 7'd16;
            default: size_bits = 7'd32;
        endcase
    endfunction

endpackage

// File: rtl/sru_shift_core.sv
module sru_shift_core
    import sru_pkg::*;
(
    input  logic [3:0]           op,
    input  logic [1:0]           size,
    input  logic [SRU_CNT_W-1:0] cnt,
    input  logic [SRU_XLEN-1:0]  dst,
    input  logic [SRU_XLEN-1:0]  src,
    output logic [SRU_XLEN-1:0]  res,
    output logic                 cf_out,
    output logic                 of_out
);
    localparam int EW = SRU_EXT_W;

    logic [SRU_XLEN-1:0] m;
    logic [6:0]          w;
    logic [7:0]          w2;
    logic [EW-1:0]       dm, sm, sx, cat, t;
    logic                sign;

    always_comb begin
        m    = size_mask(size);
        w    = size_bits(size);
        w2   = {w, 1'b0};
        dm   = {{(EW-SRU_XLEN){1'b0}}, dst & m};
        sm   = {{(EW-SRU_XLEN){1'b0}}, src & m};
        sign = dst[w-7'd1];
        sx   = {{(EW-SRU_XLEN){sign}}, (dst & m) | (sign ? ~m : '0)};
        cat  = '0;
        t    = '0;
        res  = '0;
        cf_out = 1'b0;
        of_out = 1'b0;
        case (op)
            OP_SHL: begin
                t      = dm << cnt;
                res    = t[SRU_XLEN-1:0] & m;
                cf_out = t[w];
                of_out = res[w-7'd1] ^ cf_out;
            end
            OP_SHR: begin
                t      = (dm << 1) >> cnt;
                res    = t[SRU_XLEN:1] & m;
                cf_out = t[0];
                of_out = dst[w-7'd1];
            end
            OP_SAR: begin
                t      = $unsigned($signed(sx << 1) >>> cnt);
                res    = t[SRU_XLEN:1] & m;
                cf_out = t[0];
                of_out = 1'b0;
            end
            OP_SHLD: begin
                cat    = (dm << w) | sm;
                t      = cat << cnt;
                res    = SRU_XLEN'(t >> w) & m;
                cf_out = t[w2];
                of_out = res[w-7'd1] ^ dst[w-7'd1];
            end
            OP_SHRD: begin
                cat    = (sm << w) | dm;
                t      = (cat << 1) >> cnt;
                res    = t[SRU_XLEN:1] & m;
                cf_out = t[0];
                of_out = res[w-7'd1] ^ dst[w-7'd1];
            end
            default: begin
                res = '0;
            end
        endcase
    end
endmodule

// File: rtl/sru_rotate_core.sv
module sru_rotate_core
    import sru_pkg::*;
(
    input  logic [3:0]           op,
    input  logic [1:0]           size,
    input  logic [SRU_CNT_W-1:0] cnt,
    input  logic [SRU_XLEN-1:0]  dst,
    input  logic                 cin,
    output logic [SRU_XLEN-1:0]  res,
    output logic                 cf_out,
    output logic                 of_out
);
    localparam int EW = SRU_EXT_W;

    logic [SRU_XLEN-1:0]  m;
    logic [6:0]           w, w1;
    logic [SRU_CNT_W-1:0] r_plain, r_carry;
    logic [EW-1:0]        dm, dd, v, vv, t;

    always_comb begin
        m  = size_mask(size);
        w  = size_bits(size);
        w1 = w + 7'd1;
        r_plain = cnt & SRU_CNT_W'(w - 7'd1);
        case (size)
            2'd0:    r_carry = SRU_CNT_W'(cnt % 5'd9);
            2'd1:    r_carry = SRU_CNT_W'(cnt % 5'd17);
            default: r_carry = cnt;
        endcase
        dm = {{(EW-SRU_XLEN){1'b0}}, dst & m};
        dd = dm | (dm << w);
        v  = dm | (EW'(cin) << w);
        vv = v | (v << w1);
        t  = '0;
        res = '0;
        cf_out = 1'b0;
        of_out = 1'b0;
        case (op)
            OP_ROL: begin
                t      = (dd << r_plain) >> w;
                res    = t[SRU_XLEN-1:0] & m;
                cf_out = res[0];
                of_out = res[w-7'd1] ^ res[0];
            end
            OP_ROR: begin
                t      = dd >> r_plain;
                res    = t[SRU_XLEN-1:0] & m;
                cf_out = res[w-7'd1];
                of_out = res[w-7'd1] ^ res[w-7'd2];
            end
            OP_RCL: begin
                t      = (vv << r_carry) >> w1;
                res    = t[SRU_XLEN-1:0] & m;
                cf_out = t[w];
                of_out = res[w-7'd1] ^ cf_out;
            end
            OP_RCR: begin
                t      = vv >> r_carry;
                res    = t[SRU_XLEN-1:0] & m;
                cf_out = t[w];
                of_out = res[w-7'd1] ^ res[w-7'd2];
            end
            default: begin
                res = '0;
            end
        endcase
    end
endmodule

// File: rtl/sru_flag_gen.sv
module sru_flag_gen
    import sru_pkg::*;
(
    input  logic [1:0]          size,
    input  logic [SRU_XLEN-1:0] res,
    output logic                zf_out,
    output logic                sf_out,
    output logic                pf_out
);
    logic [6:0] w;

    always_comb begin
        w      = size_bits(size);
        zf_out = ((res & size_mask(size)) == '0);
        sf_out = res[w-7'd1];
        pf_out = ~^res[7:0];
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [3:0]          op,
    input  logic [1:0]          size,
    input  logic [31:0]         dst,
    input  logic [31:0]         src,
    input  logic [7:0]          count,
    input  logic                carry_in,
    output logic                done,
    output logic [31:0]         result,
    output logic                cf,
    output logic                of,
    output logic                zf,
    output logic                sf,
    output logic                pf,
    output logic [4:0]          flag_upd,
    output logic                illegal
);
    typedef struct packed {
        logic                 done;
        logic [SRU_XLEN-1:0]  result;
        logic [SRU_NFLAG-1:0] flags;
        logic [SRU_NFLAG-1:0] upd;
        logic                 illegal;
    } sru_state_t;

    sru_state_t st_d, st_q;

    logic [SRU_CNT_W-1:0] cnt;
    logic [SRU_XLEN-1:0]  sh_res, rt_res, sel_res;
    logic                 sh_cf, sh_of, rt_cf, rt_of;
    logic                 fl_zf, fl_sf, fl_pf;
    logic                 is_rot, is_dbl, bad;
    logic [6:0]           w;

    assign cnt = count[SRU_CNT_W-1:0];

    sru_shift_core i_shift (
        .op     (op),
        .size   (size),
        .cnt    (cnt),
        .dst    (dst),
        .src    (src),
        .res    (sh_res),
        .cf_out (sh_cf),
        .of_out (sh_of)
    );

    sru_rotate_core i_rotate (
        .op     (op),
        .size   (size),
        .cnt    (cnt),
        .dst    (dst),
        .cin    (carry_in),
        .res    (rt_res),
        .cf_out (rt_cf),
        .of_out (rt_of)
    );

    assign is_rot  = (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
    assign sel_res = is_rot ? rt_res : sh_res;

    sru_flag_gen i_flags (
        .size   (size),
        .res    (sel_res),
        .zf_out (fl_zf),
        .sf_out (fl_sf),
        .pf_out (fl_pf)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        w      = size_bits(size);
        is_dbl = (op == OP_SHLD) || (op == OP_SHRD);
        bad    = (size == SZ_BAD) || (op > OP_SHRD) ||
                 (is_dbl && ((size == SZ_BYTE) || ({2'b00, cnt} >= w)));
        if (start) begin
            st_d.flags   = '0;
            st_d.upd     = '0;
            st_d.illegal = 1'b0;
            if (bad) begin
                st_d.result  = '0;
                st_d.illegal = 1'b1;
            end else if (cnt == '0) begin
                st_d.result = dst & size_mask(size);
            end else begin
                st_d.result = sel_res;
                st_d.upd[FL_CF]   = 1'b1;
                st_d.flags[FL_CF] = is_rot ? rt_cf : sh_cf;
                if (cnt == SRU_CNT_W'(1)) begin
                    st_d.upd[FL_OF]   = 1'b1;
                    st_d.flags[FL_OF] = is_rot ? rt_of : sh_of;
                end
                if (!is_rot) begin
                    st_d.upd[FL_ZF]   = 1'b1;
                    st_d.upd[FL_SF]   = 1'b1;
                    st_d.upd[FL_PF]   = 1'b1;
                    st_d.flags[FL_ZF] = fl_zf;
                    st_d.flags[FL_SF] = fl_sf;
                    st_d.flags[FL_PF] = fl_pf;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done     = st_q.done;
    assign result   = st_q.result;
    assign cf       = st_q.flags[FL_CF];
    assign of       = st_q.flags[FL_OF];
    assign zf       = st_q.flags[FL_ZF];
    assign sf       = st_q.flags[FL_SF];
    assign pf       = st_q.flags[FL_PF];
    assign flag_upd = st_q.upd;
    assign illegal  = st_q.illegal;
endmodule

// File: rtl/sru_checker.sv
module sru_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [3:0]  op,
    input logic [1:0]  size,
    input logic [7:0]  count,
    input logic        done,
    input logic [31:0] result,
    input logic        cf,
    input logic        of,
    input logic        zf,
    input logic        sf,
    input logic        pf,
    input logic [4:0]  flag_upd,
    input logic        illegal
);
    // R11
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R11
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result) && $stable(flag_upd) && $stable(illegal));

    // R4
    illegal_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (flag_upd == 5'b0) && (result == 32'b0));

    // R8
    rotate_keeps_zsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && (op >= 4'd3) && (op <= 4'd6) |=> (flag_upd[4:2] == 3'b0));

    // R3
    of_only_count_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && (count[4:0] != 5'd1) |=> !flag_upd[1]);

    // R9
    zero_count_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && (count[4:0] == 5'd0) |=> (flag_upd == 5'b0));

    // R1
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && (size == 2'd0) |=> (result[31:8] == 24'b0));

    // R10
    masked_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (({pf, sf, zf, of, cf} & ~flag_upd) == 5'b0));
endmodule

bind shift_rotate_unit sru_checker i_sru_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .size     (size),
    .count    (count),
    .done     (done),
    .result   (result),
    .cf       (cf),
    .of       (of),
    .zf       (zf),
    .sf       (sf),
    .pf       (pf),
    .flag_upd (flag_upd),
    .illegal  (illegal)
);

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] dst = '0;
    logic [31:0] src = '0;
    logic [7:0]  count = '0;
    logic        carry_in = 1'b0;
    logic        done;
    logic [31:0] result;
    logic        cf, of, zf, sf, pf;
    logic [4:0]  flag_upd;
    logic        illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    shift_rotate_unit i_shift_rotate_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .dst(dst), .src(src), .count(count), .carry_in(carry_in),
        .done(done), .result(result), .cf(cf), .of(of), .zf(zf), .sf(sf),
        .pf(pf), .flag_upd(flag_upd), .illegal(illegal)
    );

    // expected outputs
    logic [31:0] e_res;
    logic [4:0]  e_fl, e_upd;
    logic        e_ill;

    function automatic string tag_of(input int o);
        case (o)
            0, 1:    return "R1";
            2:       return "R2";
            3, 4:    return "R7";
            5, 6:    return "R6";
            7, 8:    return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic model(input int o, input int sz, input logic [31:0] d_in,
                         input logic [31:0] s_in, input int c, input logic cin);
        int w;
        logic [31:0] m, d;
        logic cfv, nb, omsb, ofv;
        w = 8 << sz;
        m = (sz == 2) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        e_res = 0; e_fl = 0; e_upd = 0; e_ill = 0;
        if (sz == 3 || o > 8 || ((o == 7 || o == 8) && (sz == 0 || c >= w))) begin
            e_ill = 1;
            return;
        end
        d = d_in & m;
        if (c == 0) begin
            e_res = d;
            return;
        end
        omsb = d[w-1];
        cfv  = cin;
        for (int i = 0; i < c; i++) begin
            case (o)
                0: begin cfv = d[w-1]; d = (d << 1) & m; end
                1: begin cfv = d[0]; d = d >> 1; end
                2: begin cfv = d[0]; d = (d >> 1) | (32'(d[w-1]) << (w-1)); end
                3: begin cfv = d[w-1]; d = ((d << 1) | 32'(cfv)) & m; end
                4: begin cfv = d[0]; d = (d >> 1) | (32'(cfv) << (w-1)); end
                5: begin nb = d[w-1]; d = ((d << 1) | 32'(cfv)) & m; cfv = nb; end
                6: begin nb = d[0]; d = (d >> 1) | (32'(cfv) << (w-1)); cfv = nb; end
                7: begin cfv = d[w-1]; d = ((d << 1) | 32'(s_in[w-1-i])) & m; end
                default: begin cfv = d[0]; d = (d >> 1) | (32'(s_in[i]) << (w-1)); end
            endcase
        end
        e_res = d;
        e_upd[0] = 1; e_fl[0] = cfv;
        if (c == 1) begin
            case (o)
                0, 3, 5: ofv = d[w-1] ^ cfv;
                1:       ofv = omsb;
                2:       ofv = 1'b0;
                4, 6:    ofv = d[w-1] ^ d[w-2];
                default: ofv = d[w-1] ^ omsb;
            endcase
            e_upd[1] = 1; e_fl[1] = ofv;
        end
        if (!(o >= 3 && o <= 6)) begin
            e_upd[4:2] = 3'b111;
            e_fl[2] = (d == 0);
            e_fl[3] = d[w-1];
            e_fl[4] = ~^d[7:0];
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(input int o, input int sz, input logic [31:0] d,
                       input logic [31:0] s, input logic [7:0] cnt8,
                       input logic cin, input string req);
        @(negedge clk);
        op = 4'(o); size = 2'(sz); dst = d; src = s; count = cnt8;
        carry_in = cin; start = 1'b1;
        model(o, sz, d, s, int'(cnt8[4:0]), cin);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && result == e_res && {pf, sf, zf, of, cf} == e_fl &&
              flag_upd == e_upd && illegal == e_ill, req, "outputs",
              {26'b0, done, result, illegal, flag_upd},
              {26'b0, 1'b1, e_res, e_ill, e_upd});
        check({pf, sf, zf, of, cf} == e_fl, "R10", "flags",
              64'({pf, sf, zf, of, cf}), 64'(e_fl));
    endtask

    logic [31:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                              32'h7FFF_FFFE, 32'hA5C3_96E1, 32'h1234_8F71};

    initial begin
        #200000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(done == 0 && result == 0 && flag_upd == 0 && illegal == 0 &&
              {pf, sf, zf, of, cf} == 0, "R12", "reset",
              {25'b0, done, result, illegal, flag_upd, pf}, 64'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 SAR rounding toward negative infinity
        run(2, 1, 32'h0000_FFF1, 0, 8'd1, 0, "R2");
        check(result == 32'h0000_FFF8 && cf == 1'b1, "R2", "sar -15",
              64'({cf, result}), 64'({1'b1, 32'h0000_FFF8}));

        // R4 illegal requests
        run(7, 0, 32'h0000_00AB, 32'hFF, 8'd3, 0, "R4");
        check(illegal == 1 && flag_upd == 0 && result == 0, "R4", "shld byte",
              64'({illegal, flag_upd, result}), 64'({1'b1, 5'b0, 32'b0}));
        run(8, 1, 32'h1234, 32'h5678, 8'd16, 0, "R4");
        run(3, 3, 32'h1234, 0, 8'd1, 0, "R4");
        run(9, 2, 32'h1234, 0, 8'd1, 0, "R4");

        // R9 count masking: 0x21 acts as 1, 0x20 acts as 0
        run(0, 2, 32'h4000_0001, 0, 8'h21, 0, "R9");
        check(result == 32'h8000_0002 && flag_upd == 5'b11111, "R9", "count 0x21",
              64'({flag_upd, result}), 64'({5'b11111, 32'h8000_0002}));
        run(1, 1, 32'hABCD_1234, 0, 8'h20, 1, "R9");
        check(result == 32'h0000_1234 && flag_upd == 0, "R9", "count 0x20",
              64'({flag_upd, result}), 64'({5'b0, 32'h0000_1234}));

        // R11 hold while idle with changed inputs
        dst = 32'hDEAD_BEEF; op = 4'd0; count = 8'd3;
        @(negedge clk);
        check(done == 0 && result == 32'h0000_1234 && flag_upd == 0, "R11", "hold",
              64'({done, result}), 64'({1'b0, 32'h0000_1234}));

        // Sweep: every op, size, count, with high count bits and both carries
        for (int o = 0; o < 9; o++)
            for (int sz = 0; sz < 3; sz++)
                for (int c = 0; c < 32; c++)
                    for (int p = 0; p < 6; p++)
                        for (int ci = 0; ci < 2; ci++) begin
                            logic [7:0] cnt8;
                            cnt8 = {3'(c + p), 5'(c)};
                            run(o, sz, pats[p], pats[5 - p], cnt8, 1'(ci),
                                (c == 1) ? "R3" : ((o >= 3 && o <= 6) ? "R8" : tag_of(o)));
                        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule